// File: doc/BRIEF.md
# SPI Flash Page-Program Controller

This block is the slave side of a small serial flash. It listens on a mode-0 SPI link made of a chip-select, a clock, a data-in and a data-out line. It accepts five instructions: write enable, status read, data read, page program, and page program while the array is being written (which it rejects). The SPI inputs pass through two-stage synchronisers into the system clock domain. Edges of the SPI clock are detected there. Incoming bits are taken on the rising edge and outgoing bits change on the falling edge.

A page-program sequence works in steps. The controller first receives a 24-bit address. It then fills a 256-byte page buffer, with the write pointer wrapping inside the addressed page. When chip select goes high at a legal point, a self-timed cycle of `PROG_CYCLES` system clocks begins. During that cycle every buffered byte is ANDed into an internal array of `MEM_PAGES` pages. The array holds 0xFF after reset. Pages `PROT_LO` to `PROT_HI` cannot be programmed while the protect input is high. The busy and write-enable flags appear on pins and in the status byte.

Top module: `spi_page_prog`

## Requirements
- R1: Programming only clears bits: each programmed byte becomes its old value ANDed with the received data byte.
- R2: A page-program instruction (opcode 0x02) changes nothing unless the write-enable flag is already set.
- R3: Status read (opcode 0x05) shifts out, MSB first and repeatedly, a byte whose bit 0 is busy and bit 1 is the write-enable flag; all other bits are 0.
- R4: Address bits 23 to 18 have no effect on which byte is programmed or read.
- R5: Data bytes that pass offset 0xFF of the addressed page continue at offset 0x00 of that same page.
- R6: If more than 256 data bytes are sent, only the final 256 are programmed. Bytes of the page that receive no data keep their value.
- R7: The program cycle starts only if chip select rises right after a whole data byte, with at least one data byte sent. Otherwise busy stays 0 and the array is unchanged.
- R8: Once started, busy is 1 for exactly `PROG_CYCLES` clocks, and the write-enable flag is 0 from the start of the cycle.
- R9: While `wp_en` is 1, a program aimed at a page from `PROT_LO` to `PROT_HI` (address bits 17:8) does not start. Pages outside that range still program.
- R10: A page-program instruction received while busy is 1 is rejected and leaves the running cycle and the array untouched.
- R11: Data read (opcode 0x03) followed by a 3-byte address returns array bytes from that address upward, one per byte slot, MSB first.
- R12: Write enable (opcode 0x06), sent while not busy, sets the write-enable flag. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_mosi | input | 1 | SPI data into the block |
| spi_miso | output | 1 | SPI data out of the block, 0 while deselected |
| wp_en | input | 1 | Enables protection of the configured page range |
| busy | output | 1 | Program cycle in progress |
| wel | output | 1 | Write-enable flag |

## Verification
A wrong write pointer, page index or byte-enable mask shows up as misplaced or missing bytes when the data-read instruction reads the array back after the cycle ends. That is a few hundred SPI clocks after the faulty program. A wrong accept decision is visible on `busy` within a handful of system clocks of chip select rising. A wrong cycle length shows up as a busy pulse whose width differs from `PROG_CYCLES`. Stale status shows in the very next status byte.

// File: rtl/spi_page_prog.sv
module spi_page_prog #(
  parameter int MEM_PAGES   = 4,
  parameter int PROG_CYCLES = 300,
  parameter int PROT_LO     = 2,
  parameter int PROT_HI     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic wp_en,
  output logic busy,
  output logic wel
);
  localparam int PGW       = $clog2(MEM_PAGES);
  localparam int AW        = PGW + 8;
  localparam int CW        = $clog2(PROG_CYCLES + 1);
  localparam int MEM_BYTES = MEM_PAGES * 256;

  typedef enum logic [2:0] {P_CMD, P_ADDR, P_DATA, P_STAT, P_READ, P_IGN} phase_t;

  logic [2:0] cs_q, sck_q;
  logic [1:0] mosi_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 3'b111; sck_q <= 3'b000; mosi_q <= 2'b00;
    end else begin
      cs_q <= {cs_q[1:0], spi_cs_n};
      sck_q <= {sck_q[1:0], spi_sck};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  wire cs_hi    = cs_q[1];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire sck_rise = ~cs_hi & sck_q[1] & ~sck_q[2];
  wire sck_fall = ~cs_hi & ~sck_q[1] & sck_q[2];

  phase_t      phase;
  logic [2:0]  bitcnt;
  logic [1:0]  acnt;
  logic [6:0]  sr;
  logic [7:0]  tx, ptr;
  logic [17:0] addr;
  logic        pp, got_data;
  logic [255:0] mask;
  logic [7:0]  pbuf [256];
  logic [7:0]  mem [MEM_BYTES];
  logic [CW-1:0]  cyc;
  logic [PGW-1:0] prog_pg;

  wire [7:0] byte_in = {sr, mosi_q[1]};
  wire byte_done = sck_rise & (bitcnt == 3'd7);
  wire pbuf_we   = byte_done & (phase == P_DATA);
  wire prot      = wp_en & (addr[17:8] >= 10'(PROT_LO)) & (addr[17:8] <= 10'(PROT_HI));
  wire start_prog = cs_rise & (phase == P_DATA) & (bitcnt == 3'd0) & got_data & ~prot;

  assign busy = (cyc != '0);
  wire [7:0]    idx8   = 8'(cyc - CW'(1));
  wire [AW-1:0] widx   = {prog_pg, idx8};
  wire          mem_we = busy & (cyc <= CW'(256)) & mask[idx8];
  wire [7:0]    prog_old = mem[widx];

  assign spi_miso = ~cs_hi & tx[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_CMD; bitcnt <= '0; acnt <= '0; sr <= '0; tx <= '0; ptr <= '0;
      addr <= '0; pp <= 1'b0; got_data <= 1'b0; mask <= '0; cyc <= '0;
      prog_pg <= '0; wel <= 1'b0;
    end else begin
      if (busy) cyc <= (cyc == CW'(PROG_CYCLES)) ? '0 : cyc + CW'(1);
      if (start_prog) begin
        cyc <= CW'(1);
        wel <= 1'b0;
        prog_pg <= addr[AW-1:8];
      end
      if (cs_hi) begin
        phase <= P_CMD;
        bitcnt <= '0;
      end else if (sck_rise) begin
        bitcnt <= bitcnt + 3'd1;
        sr <= byte_in[6:0];
        if (byte_done)
          case (phase)
            P_CMD:
              case (byte_in)
                8'h06: begin if (!busy) wel <= 1'b1; phase <= P_IGN; end
                8'h05: phase <= P_STAT;
                8'h03: begin phase <= P_ADDR; pp <= 1'b0; acnt <= '0; end
                8'h02:
                  if (wel && !busy) begin
                    phase <= P_ADDR; pp <= 1'b1; acnt <= '0;
                    mask <= '0; got_data <= 1'b0;
                  end else phase <= P_IGN;
                default: phase <= P_IGN;
              endcase
            P_ADDR: begin
              addr <= {addr[9:0], byte_in};
              acnt <= acnt + 2'd1;
              if (acnt == 2'd2) begin
                phase <= pp ? P_DATA : P_READ;
                ptr <= byte_in;
              end
            end
            P_DATA: begin
              mask[ptr] <= 1'b1;
              ptr <= ptr + 8'd1;
              got_data <= 1'b1;
            end
            default: ;
          endcase
      end else if (sck_fall && (phase == P_STAT || phase == P_READ)) begin
        if (bitcnt == 3'd0) begin
          tx <= (phase == P_STAT) ? {6'b0, wel, busy} : mem[addr[AW-1:0]];
          if (phase == P_READ) addr <= addr + 18'd1;
        end else tx <= {tx[6:0], 1'b0};
      end
    end

  always_ff @(posedge clk)
    if (pbuf_we) pbuf[ptr] <= byte_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (mem_we) begin
      mem[widx] <= prog_old & pbuf[idx8];
    end

  assert_program_clears_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ((mem[$past(widx)] & ~$past(prog_old)) == 8'h00));
  assert_start_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |-> wel);
  assert_wel_low_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wel);
  assert_no_restart_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |-> !busy);
endmodule

// File: tb/tb_spi_page_prog.sv
module tb_spi_page_prog;
  localparam int PROG = 3000;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp = 1'b0;
  logic miso, busy, wel;

  spi_page_prog #(.MEM_PAGES(4), .PROG_CYCLES(PROG), .PROT_LO(2), .PROT_HI(3)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .wp_en(wp), .busy(busy), .wel(wel));

  typedef struct { logic [7:0] val; string req; } item_t;
  item_t exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] pdata[$];
  logic [7:0] model [1024];
  int checks = 0, fails = 0;
  int blen = 0, last_blen = 0;
  logic [7:0] dummy;

  always @(negedge clk)
    if (busy) blen++;
    else begin
      if (blen != 0) last_blen = blen;
      blen = 0;
    end

  always @(negedge clk)
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      item_t e;
      logic [7:0] g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      checks++;
      if (g !== e.val) begin
        fails++;
        $display("FAIL %s actual=%02h expected=%02h", e.req, g, e.val);
      end
    end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic xfer(input logic [7:0] t, input int nb, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = t[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] r;
    xfer(a[23:16], 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
  endtask

  task automatic wren();
    logic [7:0] r;
    sel(); xfer(8'h06, 8, r); desel();
  endtask

  task automatic status(input logic [7:0] expv, input string req);
    logic [7:0] r;
    sel(); xfer(8'h05, 8, r);
    for (int k = 0; k < 2; k++) begin
      exp_q.push_back('{expv, req});
      xfer(8'h00, 8, r);
      got_q.push_back(r);
    end
    desel();
  endtask

  task automatic read_chk(input logic [23:0] a, input int n, input string req);
    logic [7:0] r;
    for (int k = 0; k < n; k++) exp_q.push_back('{model[(a[9:0] + k) % 1024], req});
    sel(); xfer(8'h03, 8, r); send_addr(a);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, r);
      got_q.push_back(r);
    end
    desel();
  endtask

  task automatic pp(input logic [23:0] a);
    logic [7:0] r;
    sel(); xfer(8'h02, 8, r); send_addr(a);
    foreach (pdata[k]) xfer(pdata[k], 8, r);
    desel();
  endtask

  task automatic apply_model(input logic [23:0] a);
    logic [7:0] buff [256];
    bit used [256];
    logic [7:0] p;
    p = a[7:0];
    for (int k = 0; k < 256; k++) used[k] = 0;
    foreach (pdata[k]) begin
      buff[p] = pdata[k]; used[p] = 1; p = p + 8'd1;
    end
    for (int k = 0; k < 256; k++)
      if (used[k]) model[{a[9:8], 8'(k)}] &= buff[k];
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    for (int k = 0; k < 1024; k++) model[k] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 reset busy", busy, 0);
    chk("R12 reset wel", wel, 0);
    status(8'h00, "R3 idle status");

    pdata = '{8'h00};
    pp(24'h000000);
    chk("R2 no start without wel", busy, 0);
    read_chk(24'h000000, 2, "R2 unchanged");

    wren();
    chk("R12 wel set", wel, 1);
    status(8'h02, "R3 wel status");

    pdata = '{8'hA5, 8'h3C};
    pp(24'h000010);
    apply_model(24'h000010);
    chk("R8 busy after start", busy, 1);
    chk("R8 wel cleared", wel, 0);
    status(8'h01, "R3 busy status");
    wren();
    pdata = '{8'h00};
    pp(24'h000040);
    chk("R10 still busy", busy, 1);
    wait_idle();
    chk("R8 busy length", last_blen, PROG);
    read_chk(24'h00000E, 6, "R6 partial page");
    read_chk(24'h000040, 1, "R10 rejected");
    read_chk(24'h000010, 2, "R11 read");

    wren();
    pdata = '{8'h0F, 8'hF0};
    pp(24'h000010);
    apply_model(24'h000010);
    wait_idle();
    read_chk(24'h000010, 2, "R1 and");

    wren();
    pdata = '{8'h11, 8'h22, 8'h33, 8'h44};
    pp(24'hFC01FE);
    apply_model(24'h0001FE);
    wait_idle();
    read_chk(24'h000100, 3, "R5 wrap");
    read_chk(24'hFC01FD, 4, "R4 high bits");

    wren();
    sel(); xfer(8'h02, 8, r); send_addr(24'h000180);
    xfer(8'h00, 8, r); xfer(8'h00, 4, r);
    desel();
    chk("R7 partial byte", busy, 0);
    sel(); xfer(8'h02, 8, r); send_addr(24'h000190); desel();
    chk("R7 no data", busy, 0);
    read_chk(24'h000180, 1, "R7 partial unchanged");
    read_chk(24'h000190, 1, "R7 empty unchanged");

    wp = 1'b1;
    pdata = '{8'h00};
    pp(24'h000200);
    chk("R9 protected", busy, 0);
    read_chk(24'h000200, 1, "R9 protected unchanged");
    pdata = '{8'h5A};
    pp(24'h000120);
    apply_model(24'h000120);
    chk("R9 unprotected page", busy, 1);
    wait_idle();
    read_chk(24'h000120, 1, "R9 unprotected data");
    wp = 1'b0;

    wren();
    pdata.delete();
    for (int k = 0; k < 260; k++) pdata.push_back(8'((k * 7 + 3) ^ (k >> 2)));
    pp(24'h000380);
    apply_model(24'h000380);
    wait_idle();
    read_chk(24'h000300, 256, "R6 overflow");

    repeat (40) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule